// File: doc/BRIEF.md
# Fifteen-Cent Coin Credit Controller

This block is the control core of a single-item vending machine whose item costs fifteen cents. It accepts five-cent and ten-cent coin pulses, keeps the credit collected so far in a small encoded state register, and answers two customer requests: one asks for the item, the other asks for the money back. The controller drives one strobe that releases the item and three strobes that pay back five, ten or fifteen cents.

Each clock cycle the controller looks at its four request inputs, picks the one with the highest priority, and decides both the next credit and the strobe to fire. Every input combination from every credit value has a defined result, so the machine can never stall or wander. Strobes come from flip-flops, so the actuators downstream see clean single-cycle pulses one clock after the request was sampled. Coins that would take the credit past the price are not lost: the credit saturates at fifteen cents and the surplus is paid back at once.

Top module: `vend_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, all four strobes are low and the credit is zero, so a refund request made right after reset fires no strobe.
- R2: With credit below the price and no higher-priority request, a nickel adds five cents and a dime adds ten cents to the credit.
- R3: A coin that would lift the credit past fifteen cents sets it to fifteen and fires the refund strobe for the surplus (nickel at 15 gives `ret_5`; dime at 10 gives `ret_5`; dime at 15 gives `ret_10`).
- R4: An item request at fifteen cents of credit fires `drop_item` for one cycle and clears the credit to zero.
- R5: An item request with credit below fifteen cents fires no strobe and leaves the credit unchanged.
- R6: A refund request fires the one refund strobe equal to the credit held (5 cents `ret_5`, 10 cents `ret_10`, 15 cents `ret_15`), fires nothing at zero credit, and clears the credit to zero.
- R7: When several inputs are high in one cycle only the highest is acted on, in the order refund, item request, dime, nickel; the lower ones are ignored, including when the winning item request is itself ignored under R5.
- R8: Strobes are registered: a request sampled at a rising edge shows on the strobes after that edge and not before, each strobe lasts exactly one cycle, and at most one strobe is high in any cycle.
- R9: With no input high the credit holds and no strobe fires.
- R10: The credit register uses a 2-bit code (0 cents = 00, 5 = 01, 10 = 10, 15 = 11); any code not listed is treated as zero credit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| coin_nickel | input | 1 | One-cycle pulse: a five-cent coin was accepted |
| coin_dime | input | 1 | One-cycle pulse: a ten-cent coin was accepted |
| req_item | input | 1 | Customer asks for the item |
| req_refund | input | 1 | Customer asks for the inserted money back |
| drop_item | output | 1 | Release-item strobe |
| ret_5 | output | 1 | Pay back five cents strobe |
| ret_10 | output | 1 | Pay back ten cents strobe |
| ret_15 | output | 1 | Pay back fifteen cents strobe |

## Verification
The bench builds the controller with its default parameters only, a 2-bit credit code with all four codes in use, so every credit value can be reached with a few nickels and the whole space of four credit values times sixteen input combinations is swept. After each swept cycle the hidden credit is brought out through a refund request, which shows whether ignored inputs really left it alone. A separate scenario samples the strobes on both sides of the edge to pin down the one-cycle delay and pulse length.

// File: rtl/vend_pkg.sv
package vend_pkg;

  localparam int CRED_W  = 2;
  localparam int NUM_OUT = 4;

  typedef enum logic [CRED_W-1:0] {
    CR0  = 2'b00,
    CR5  = 2'b01,
    CR10 = 2'b10,
    CR15 = 2'b11
  } credit_e;

  typedef enum logic [2:0] {
    CMD_IDLE,
    CMD_NICKEL,
    CMD_DIME,
    CMD_VEND,
    CMD_REFUND
  } cmd_e;

  typedef struct packed {
    logic drop;
    logic r15;
    logic r10;
    logic r5;
  } strobe_t;

  localparam strobe_t STROBE_NONE = '0;

endpackage

// File: rtl/vend_arbiter.sv
module vend_arbiter
  import vend_pkg::*;
(
  input  logic nickel,
  input  logic dime,
  input  logic vend,
  input  logic refund,
  output cmd_e cmd
);

  always_comb begin
    if (refund)      cmd = CMD_REFUND;
    else if (vend)   cmd = CMD_VEND;
    else if (dime)   cmd = CMD_DIME;
    else if (nickel) cmd = CMD_NICKEL;
    else             cmd = CMD_IDLE;
  end

endmodule

// File: rtl/vend_next.sv
module vend_next
  import vend_pkg::*;
(
  input  credit_e cur,
  input  cmd_e    cmd,
  output credit_e nxt,
  output strobe_t fire
);

  credit_e cur_safe;

  always_comb begin
    case (cur)
      CR5:     cur_safe = CR5;
      CR10:    cur_safe = CR10;
      CR15:    cur_safe = CR15;
      default: cur_safe = CR0;
    endcase
  end

  always_comb begin
    nxt  = cur_safe;
    fire = STROBE_NONE;
    case (cmd)
      CMD_REFUND: begin
        nxt = CR0;
        case (cur_safe)
          CR5:     fire.r5  = 1'b1;
          CR10:    fire.r10 = 1'b1;
          CR15:    fire.r15 = 1'b1;
          default: fire     = STROBE_NONE;
        endcase
      end
      CMD_VEND: begin
        if (cur_safe == CR15) begin
          nxt       = CR0;
          fire.drop = 1'b1;
        end
      end
      CMD_DIME: begin
        case (cur_safe)
          CR0:     nxt = CR10;
          CR5:     nxt = CR15;
          CR10:    begin nxt = CR15; fire.r5  = 1'b1; end
          default: begin nxt = CR15; fire.r10 = 1'b1; end
        endcase
      end
      CMD_NICKEL: begin
        case (cur_safe)
          CR0:     nxt = CR5;
          CR5:     nxt = CR10;
          CR10:    nxt = CR15;
          default: begin nxt = CR15; fire.r5 = 1'b1; end
        endcase
      end
      default: begin
        nxt  = cur_safe;
        fire = STROBE_NONE;
      end
    endcase
  end

endmodule

// File: rtl/vend_outreg.sv
module vend_outreg
  import vend_pkg::*;
#(
  parameter int W = NUM_OUT
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
  import vend_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic coin_nickel,
  input  logic coin_dime,
  input  logic req_item,
  input  logic req_refund,
  output logic drop_item,
  output logic ret_5,
  output logic ret_10,
  output logic ret_15
);

  cmd_e    cmd;
  credit_e credit_q;
  credit_e credit_d;
  strobe_t fire_d;
  strobe_t fire_q;

  vend_arbiter u_arb (
    .nickel (coin_nickel),
    .dime   (coin_dime),
    .vend   (req_item),
    .refund (req_refund),
    .cmd    (cmd)
  );

  vend_next u_next (
    .cur  (credit_q),
    .cmd  (cmd),
    .nxt  (credit_d),
    .fire (fire_d)
  );

  always_ff @(posedge clk) begin
    if (rst) credit_q <= CR0;
    else     credit_q <= credit_d;
  end

  vend_outreg #(.W(NUM_OUT)) u_oreg (
    .clk (clk),
    .rst (rst),
    .d   (fire_d),
    .q   (fire_q)
  );

  assign drop_item = fire_q.drop;
  assign ret_15    = fire_q.r15;
  assign ret_10    = fire_q.r10;
  assign ret_5     = fire_q.r5;

endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk
  import vend_pkg::*;
(
  input logic    clk,
  input logic    rst,
  input logic    coin_nickel,
  input logic    coin_dime,
  input logic    req_item,
  input logic    req_refund,
  input logic    drop_item,
  input logic    ret_5,
  input logic    ret_10,
  input logic    ret_15,
  input credit_e credit_q
);

  // R8: never two strobes together
  a_r8_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({drop_item, ret_5, ret_10, ret_15}));

  // R6: refund always leaves zero credit
  a_r6_refund_clears: assert property (@(posedge clk) disable iff (rst)
    req_refund |=> credit_q == CR0);

  // R6: refund with no credit fires nothing
  a_r6_empty_refund: assert property (@(posedge clk) disable iff (rst)
    (req_refund && credit_q == CR0) |=> !(drop_item || ret_5 || ret_10 || ret_15));

  // R4: drop only after a winning item request at full credit
  a_r4_drop_cause: assert property (@(posedge clk) disable iff (rst)
    drop_item |-> $past(req_item && !req_refund && credit_q == CR15));

  // R5: item request below price keeps credit
  a_r5_hold_credit: assert property (@(posedge clk) disable iff (rst)
    (req_item && !req_refund && credit_q != CR15) |=> $stable(credit_q) && !drop_item);

  // R3: nickel at full credit saturates and returns five
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (coin_nickel && !coin_dime && !req_item && !req_refund && credit_q == CR15)
      |=> (credit_q == CR15) && ret_5);

  // R9: idle holds credit
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !(coin_nickel || coin_dime || req_item || req_refund) |=> $stable(credit_q) && !ret_5 && !ret_10 && !ret_15 && !drop_item);

endmodule

bind vend_ctrl vend_ctrl_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .coin_nickel (coin_nickel),
  .coin_dime   (coin_dime),
  .req_item    (req_item),
  .req_refund  (req_refund),
  .drop_item   (drop_item),
  .ret_5       (ret_5),
  .ret_10      (ret_10),
  .ret_15      (ret_15),
  .credit_q    (credit_q)
);

// File: tb/sim_vend_ctrl.sv
`timescale 1ns/1ps
module sim_vend_ctrl;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic coin_nickel = 1'b0, coin_dime = 1'b0, req_item = 1'b0, req_refund = 1'b0;
  logic drop_item, ret_5, ret_10, ret_15;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  vend_ctrl u0 (
    .clk(clk), .rst(rst),
    .coin_nickel(coin_nickel), .coin_dime(coin_dime),
    .req_item(req_item), .req_refund(req_refund),
    .drop_item(drop_item), .ret_5(ret_5), .ret_10(ret_10), .ret_15(ret_15)
  );

  // strobe vector order {drop, r15, r10, r5}; input order {nickel, dime, item, refund}
  function automatic logic [3:0] outs();
    return {drop_item, ret_15, ret_10, ret_5};
  endfunction

  function automatic logic [3:0] refund_vec(input int s);
    case (s)
      1: return 4'b0001;
      2: return 4'b0010;
      3: return 4'b0100;
      default: return 4'b0000;
    endcase
  endfunction

  // expected behaviour from the requirements; credit s in units of 5 cents
  task automatic model(input int s, input logic [3:0] in, output int ns, output logic [3:0] o);
    o = 4'b0000; ns = s;
    if (in[0]) begin ns = 0; o = refund_vec(s); end
    else if (in[1]) begin if (s == 3) begin ns = 0; o = 4'b1000; end end
    else if (in[2]) begin ns = s + 2; if (ns > 3) begin o = refund_vec(ns - 3); ns = 3; end end
    else if (in[3]) begin ns = s + 1; if (ns > 3) begin o = refund_vec(ns - 3); ns = 3; end end
  endtask

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: strobes actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [3:0] in, output logic [3:0] o);
    {coin_nickel, coin_dime, req_item, req_refund} = in;
    @(posedge clk); #1;
    o = outs();
    @(negedge clk);
    {coin_nickel, coin_dime, req_item, req_refund} = 4'b0000;
  endtask

  task automatic go_to(input int s);
    logic [3:0] o;
    cyc(4'b0001, o);
    for (int k = 0; k < s; k++) cyc(4'b1000, o);
  endtask

  task automatic t_reset();
    logic [3:0] o;
    rst = 1'b1;
    {coin_nickel, coin_dime, req_item, req_refund} = 4'b1111;
    repeat (3) @(posedge clk);
    #1 check("R1 during reset", outs(), 4'b0000);
    @(negedge clk);
    {coin_nickel, coin_dime, req_item, req_refund} = 4'b0000;
    rst = 1'b0;
    #1 check("R1 after reset", outs(), 4'b0000);
    cyc(4'b0001, o);
    check("R1 zero credit refund", o, 4'b0000);
  endtask

  task automatic t_sweep();
    logic [3:0] o;
    int ns;
    logic [3:0] eo;
    string tag;
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 16; c++) begin
        go_to(s);
        model(s, c[3:0], ns, eo);
        if (c[0])      tag = (c[3:1] != 0) ? "R7 refund wins" : "R6 refund";
        else if (c[1]) tag = (c[3:2] != 0) ? "R7 item wins" : (s == 3 ? "R4 vend" : "R5 vend ignored");
        else if (c[2]) tag = (s + 2 > 3) ? "R3 dime overflow" : "R2 dime";
        else if (c[3]) tag = (s == 3) ? "R3 nickel overflow" : "R2 nickel";
        else           tag = "R9 idle";
        cyc(c[3:0], o);
        check(tag, o, eo);
        cyc(4'b0000, o);
        check("R8 pulse ends", o, 4'b0000);
        cyc(4'b0001, o);
        check({tag, " R10 credit probe"}, o, refund_vec(ns));
      end
    end
  endtask

  task automatic t_timing();
    logic [3:0] o;
    go_to(3);
    {coin_nickel, coin_dime, req_item, req_refund} = 4'b0010;
    #1 check("R8 no strobe before edge", outs(), 4'b0000);
    @(posedge clk); #1;
    check("R8 drop after edge", outs(), 4'b1000);
    @(negedge clk);
    {coin_nickel, coin_dime, req_item, req_refund} = 4'b0000;
    @(posedge clk); #1;
    check("R8 drop lasts one cycle", outs(), 4'b0000);
    @(negedge clk);
    cyc(4'b0001, o);
    check("R4 credit zero after drop", o, 4'b0000);
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_sweep();
    t_timing();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule